// File: doc/BRIEF.md
# Nonvolatile Memory Access Controller

This block sits between a processor core and two small nonvolatile arrays: a 64-byte data memory and a program memory of 2K words, each word 14 bits wide. Software drives it through six byte-wide registers on a simple single-cycle bus. These are a control register, an unlock register, two address bytes and two data bytes. A read is a one-cycle strobe toward the selected array, and the returned value lands in the data registers. A write is a timed cycle whose length comes from a parameter. It commits the data registers to the array when the count ends.

A write is guarded in two ways. The write-enable bit must already be set. The start request must also follow directly after an unlock pair written to the unlock register. During a program-memory write the core is held by a stall output, and interrupt requests that arrive meanwhile are held back and released when the write ends. A warm reset (external or watchdog) that cuts a write short flags an error. It keeps the address, data and target-select state so that software can retry. A separate power-on reset clears everything.

Register offsets on `bus_addr`: 0 control, 1 unlock, 2 address low, 3 address high, 4 data low, 5 data high. Control bits: 0 read-go, 1 write-go, 2 write-enable, 3 write-error, 4 write-done, 7 target-select; bits 5 and 6 read 0.

Top module: `nvm_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low at a clock edge), every register reads 0x00, `cpu_stall` is 0 and `irq_out` is 0.
- R2: The unlock register (offset 1) has no storage and always reads 0x00, whatever was written to it.
- R3: Setting read-go (control bit 0) drives `nvm_rd` for exactly one cycle, and the data registers hold the array value from the next cycle on, when read-go again reads 0. With target-select 1 both data bytes load the 14-bit word (low 8 bits to offset 4, upper 6 to offset 5). With target-select 0 only the low data byte loads and the high data byte is left unchanged.
- R4: With target-select 0 the array address is bits [5:0] of the address-low register, so address-low values above 0x3F wrap. With target-select 1 it is {address-high[4:0], address-low}.
- R5: Unused upper bits read 0: address-high bits [7:5] and data-high bits [7:6].
- R6: Write-go is set only by a control write with bit 1 set, while write-enable is already 1, immediately after a write of 0x55 and then 0xAA to the unlock register with no other bus access (read or write) in between. Otherwise the write is ignored and the array is unchanged.
- R7: Bus writes cannot clear read-go or write-go. A write keeps write-go high for exactly WR_CYCLES cycles. It drives `nvm_wr` in its last cycle, and then clears write-go and sets write-done (bit 4, also on `done_irq`).
- R8: Write-done stays set until software writes the control register with bit 4 at 0. Writing 1 to it never sets it.
- R9: While a read or write is in progress, bus writes cannot change target-select, the address registers or the data registers.
- R10: `cpu_stall` is high for every cycle of a program-memory write and stays low during a data-memory write.
- R11: Outside a stall, `irq_out` follows `irq_in`. During a stall, `irq_out` is 0 and any request seen is held, then shown on `irq_out` for the first cycle after the stall ends.
- R12: A warm reset (`rst_n` low, `por_n` high) during a write aborts it without committing. It sets write-error (bit 3) and clears write-enable and write-done. It keeps target-select, address and data registers. Write-error clears only when software writes bit 3 as 0 or on power-on reset.
- R13: Power-on reset clears write-error, target-select and all address and data registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low, clears all state |
| rst_n | input | 1 | Warm reset, synchronous, active low, keeps address, data and select |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (also breaks the unlock pair) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| nvm_sel | output | 1 | Array select: 1 program memory, 0 data memory |
| nvm_addr | output | 13 | Array address |
| nvm_wdata | output | 14 | Array write data |
| nvm_rd | output | 1 | Array read strobe |
| nvm_wr | output | 1 | Array commit strobe |
| nvm_rdata | input | 14 | Array read data (data memory uses bits [7:0]) |
| cpu_stall | output | 1 | Core stall during a program-memory write |
| done_irq | output | 1 | Write-done interrupt flag |
| irq_in | input | IRQ_W | Interrupt requests from the rest of the chip |
| irq_out | output | IRQ_W | Interrupt requests passed on to the core |

## Verification
The bench builds the controller with WR_CYCLES = 6 and IRQ_W = 3, while the address and data widths keep their defaults. The short write window lets the bench count every cycle of a write exactly. Within that window it can slip a bus write, an interrupt pulse and a warm reset into the middle of a write. The default address widths keep both the 6-bit wrap of the data memory and the 13-bit program address in view.

// File: rtl/nvm_pkg.sv
// Shared register offsets, control bit positions and unlock codes for the
// nonvolatile memory access controller. Assumes a 3-bit register offset.
package nvm_pkg;
    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_KEY   = 3'd1;
    localparam logic [2:0] REG_ADLO  = 3'd2;
    localparam logic [2:0] REG_ADHI  = 3'd3;
    localparam logic [2:0] REG_DLO   = 3'd4;
    localparam logic [2:0] REG_DHI   = 3'd5;

    localparam int CB_RD   = 0;
    localparam int CB_WR   = 1;
    localparam int CB_WREN = 2;
    localparam int CB_ERR  = 3;
    localparam int CB_DONE = 4;
    localparam int CB_SEL  = 7;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_OPEN  = 2'd2
    } key_state_e;
endpackage

// File: rtl/nvm_unlock.sv
// Tracks the two-step unlock pair written to the unlock register.
// Assumes one bus access per cycle. Any access that is not the next step
// of the pair returns the tracker to idle. The state after the second step
// is consumed by whatever access comes next.
module nvm_unlock
    import nvm_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic       bus_re,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic       armed
);
    key_state_e st_q, st_d;

    // Next state: advance on a matching step, fall back to idle on any other access.
    always_comb begin
        st_d = st_q;
        if (bus_we || bus_re) begin
            st_d = KEY_IDLE;
            if (bus_we && bus_addr == REG_KEY) begin
                if (bus_wdata == KEY_FIRST) begin
                    st_d = KEY_HALF;
                end else if (bus_wdata == KEY_SECOND && st_q == KEY_HALF) begin
                    st_d = KEY_OPEN;
                end
            end
        end
    end

    // State register, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            st_q <= KEY_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = (st_q == KEY_OPEN);
endmodule

// File: rtl/nvm_seq.sv
// Read and write sequencer. A read is one strobe cycle. A write runs for
// WR_CYCLES cycles and commits in its last one. Assumes the start inputs
// pulse only while idle and that WR_CYCLES is at least 1.
module nvm_seq #(
    parameter int WR_CYCLES = 4000
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic rd_start,
    input  logic wr_start,
    output logic rd_busy,
    output logic wr_busy,
    output logic rd_strobe,
    output logic wr_commit
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic             rd_q;
    logic             wr_q;
    logic [CNT_W-1:0] cnt_q;

    // Operation state and write countdown, dropped by either reset.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            rd_q <= rd_start;
            if (wr_start) begin
                wr_q  <= 1'b1;
                cnt_q <= CNT_W'(WR_CYCLES);
            end else if (wr_q) begin
                if (cnt_q == CNT_W'(1)) begin
                    wr_q <= 1'b0;
                end
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign rd_busy   = rd_q;
    assign wr_busy   = wr_q;
    assign rd_strobe = rd_q;
    assign wr_commit = wr_q && (cnt_q == CNT_W'(1)) && rst_n && por_n;
endmodule

// File: rtl/nvm_irq_hold.sv
// Holds interrupt requests back while the core is stalled. Requests seen
// during the stall are collected and shown for one cycle once it ends.
// Assumes the stall input is registered.
module nvm_irq_hold #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] irq_in,
    output logic [W-1:0] irq_out
);
    logic [W-1:0] pend_q;

    // Collect requests while holding, drop them once they have been shown.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            pend_q <= '0;
        end else if (hold) begin
            pend_q <= pend_q | irq_in;
        end else begin
            pend_q <= '0;
        end
    end

    assign irq_out = hold ? '0 : (irq_in | pend_q);
endmodule

// File: rtl/nvm_ctrl.sv
// Register-mapped access controller for a byte-wide data memory and a
// word-wide program memory. It holds the control, address and data
// registers. It decodes the single-cycle register bus, and drives the
// sequencer, the unlock tracker and the interrupt hold stage. Assumes the
// arrays answer a read combinationally and commit on nvm_wr at the clock edge.
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int WR_CYCLES = 4000,
    parameter int IRQ_W     = 4,
    parameter int AHI_W     = 5,
    parameter int DHI_W     = 6,
    parameter int DM_AW     = 6
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic                  bus_re,
    input  logic [2:0]            bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  nvm_sel,
    output logic [8+AHI_W-1:0]    nvm_addr,
    output logic [8+DHI_W-1:0]    nvm_wdata,
    output logic                  nvm_rd,
    output logic                  nvm_wr,
    input  logic [8+DHI_W-1:0]    nvm_rdata,
    output logic                  cpu_stall,
    output logic                  done_irq,
    input  logic [IRQ_W-1:0]      irq_in,
    output logic [IRQ_W-1:0]      irq_out
);
    localparam int ADDR_W = 8 + AHI_W;
    localparam int DATA_W = 8 + DHI_W;

    logic             sel_q, wren_q, err_q, done_q;
    logic [7:0]       adlo_q, dlo_q;
    logic [AHI_W-1:0] adhi_q;
    logic [DHI_W-1:0] dhi_q;

    logic bus_ok, wr_ctrl, armed, busy;
    logic rd_start, wr_start, rd_busy, wr_busy;

    assign bus_ok   = bus_we && rst_n;
    assign wr_ctrl  = bus_ok && (bus_addr == REG_CTRL);
    assign busy     = rd_busy || wr_busy;
    assign wr_start = wr_ctrl && bus_wdata[CB_WR] && wren_q && armed && !busy;
    assign rd_start = wr_ctrl && bus_wdata[CB_RD] && !busy && !wr_start;

    nvm_unlock u_unlock (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .armed     (armed)
    );

    nvm_seq #(.WR_CYCLES(WR_CYCLES)) u_seq (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .rd_start  (rd_start),
        .wr_start  (wr_start),
        .rd_busy   (rd_busy),
        .wr_busy   (wr_busy),
        .rd_strobe (nvm_rd),
        .wr_commit (nvm_wr)
    );

    nvm_irq_hold #(.W(IRQ_W)) u_irq (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .hold    (cpu_stall),
        .irq_in  (irq_in),
        .irq_out (irq_out)
    );

    // Control flags: cleared by power-on, partly kept across warm reset.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            sel_q  <= 1'b0;
            wren_q <= 1'b0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (!rst_n) begin
            wren_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= err_q | wr_busy;
        end else begin
            if (nvm_wr) begin
                done_q <= 1'b1;
            end else if (wr_ctrl) begin
                done_q <= done_q & bus_wdata[CB_DONE];
            end
            if (wr_ctrl) begin
                err_q  <= err_q & bus_wdata[CB_ERR];
                wren_q <= bus_wdata[CB_WREN];
                if (!busy) begin
                    sel_q <= bus_wdata[CB_SEL];
                end
            end
        end
    end

    // Address and data registers: read results win over bus writes, both blocked while busy.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            adlo_q <= '0;
            adhi_q <= '0;
            dlo_q  <= '0;
            dhi_q  <= '0;
        end else if (rd_busy && rst_n) begin
            dlo_q <= nvm_rdata[7:0];
            if (sel_q) begin
                dhi_q <= nvm_rdata[DATA_W-1:8];
            end
        end else if (bus_ok && !busy) begin
            case (bus_addr)
                REG_ADLO: adlo_q <= bus_wdata;
                REG_ADHI: adhi_q <= bus_wdata[AHI_W-1:0];
                REG_DLO:  dlo_q  <= bus_wdata;
                REG_DHI:  dhi_q  <= bus_wdata[DHI_W-1:0];
                default:  ;
            endcase
        end
    end

    // Register read mux; the unlock register and unused offsets read zero.
    always_comb begin
        case (bus_addr)
            REG_CTRL: bus_rdata = {sel_q, 2'b00, done_q, err_q, wren_q, wr_busy, rd_busy};
            REG_ADLO: bus_rdata = adlo_q;
            REG_ADHI: bus_rdata = {{(8-AHI_W){1'b0}}, adhi_q};
            REG_DLO:  bus_rdata = dlo_q;
            REG_DHI:  bus_rdata = {{(8-DHI_W){1'b0}}, dhi_q};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign nvm_sel   = sel_q;
    assign nvm_addr  = sel_q ? {adhi_q, adlo_q} : ADDR_W'(adlo_q[DM_AW-1:0]);
    assign nvm_wdata = sel_q ? {dhi_q, dlo_q} : DATA_W'(dlo_q);
    assign cpu_stall = wr_busy && sel_q;
    assign done_irq  = done_q;
endmodule

// File: rtl/nvm_ctrl_chk.sv
// Property checker for nvm_ctrl, attached by bind. Observes ports and the
// control state only; drives nothing.
module nvm_ctrl_chk
    import nvm_pkg::*;
#(
    parameter int IRQ_W = 4,
    parameter int AHI_W = 5,
    parameter int DHI_W = 6
) (
    input logic             clk,
    input logic             por_n,
    input logic             rst_n,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_rdata,
    input logic             nvm_rd,
    input logic             nvm_wr,
    input logic             cpu_stall,
    input logic [IRQ_W-1:0] irq_out,
    input logic             sel_q,
    input logic             err_q,
    input logic             done_q,
    input logic             rd_busy,
    input logic             wr_busy
);
    p_key_reads_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
        (bus_addr == REG_KEY) |-> (bus_rdata == 8'h00));

    p_adhi_upper_zero_r5: assert property (@(posedge clk) disable iff (!por_n)
        (bus_addr == REG_ADHI) |-> (bus_rdata[7:AHI_W] == '0));

    p_dhi_upper_zero_r5: assert property (@(posedge clk) disable iff (!por_n)
        (bus_addr == REG_DHI) |-> (bus_rdata[7:DHI_W] == '0));

    p_read_one_cycle_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        nvm_rd |=> !nvm_rd);

    p_commit_sets_done_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        nvm_wr |=> (done_q && !wr_busy));

    p_sel_locked_r9: assert property (@(posedge clk) disable iff (!por_n)
        (rd_busy || wr_busy) |=> $stable(sel_q));

    p_irq_held_r11: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        cpu_stall |-> (irq_out == '0));

    p_no_commit_in_reset_r12: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |-> !nvm_wr);

    p_abort_flags_error_r12: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && wr_busy) |=> err_q);

    p_por_clears_r13: assert property (@(posedge clk)
        !por_n |=> (!err_q && !sel_q && !done_q && !wr_busy));
endmodule

bind nvm_ctrl nvm_ctrl_chk #(
    .IRQ_W (IRQ_W),
    .AHI_W (AHI_W),
    .DHI_W (DHI_W)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .nvm_rd    (nvm_rd),
    .nvm_wr    (nvm_wr),
    .cpu_stall (cpu_stall),
    .irq_out   (irq_out),
    .sel_q     (sel_q),
    .err_q     (err_q),
    .done_q    (done_q),
    .rd_busy   (rd_busy),
    .wr_busy   (wr_busy)
);

// File: tb/tb_nvm_ctrl.sv
module tb_nvm_ctrl;
    localparam int WR_CYC = 6;
    localparam int IRQ_W  = 3;

    localparam logic [2:0] A_CTRL = 3'd0, A_KEY = 3'd1, A_ADLO = 3'd2,
                           A_ADHI = 3'd3, A_DLO = 3'd4, A_DHI = 3'd5;
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [2:0] addr;
        logic [7:0] data;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VEC [0:NV-1] = '{
        '{OP_R, A_CTRL, 8'h00, 8'd1},   // R1 reset state
        '{OP_R, A_ADLO, 8'h00, 8'd1},
        '{OP_R, A_DHI,  8'h00, 8'd1},
        '{OP_W, A_ADHI, 8'hFF, 8'd0},
        '{OP_R, A_ADHI, 8'h1F, 8'd5},   // R5 upper address bits
        '{OP_W, A_ADHI, 8'h01, 8'd0},
        '{OP_W, A_ADLO, 8'h23, 8'd0},
        '{OP_W, A_CTRL, 8'h81, 8'd0},   // program read at 0x123
        '{OP_I, 3'd0,   8'h00, 8'd0},
        '{OP_R, A_DLO,  8'h14, 8'd3},   // R3 word low
        '{OP_R, A_DHI,  8'h2A, 8'd3},   // R3 word high
        '{OP_R, A_CTRL, 8'h80, 8'd3},   // R3 read-go self clears
        '{OP_W, A_CTRL, 8'h01, 8'd0},   // data read at 0x23
        '{OP_I, 3'd0,   8'h00, 8'd0},
        '{OP_R, A_DLO,  8'h6A, 8'd4},   // R4
        '{OP_R, A_DHI,  8'h2A, 8'd3},   // R3 high byte untouched
        '{OP_W, A_ADLO, 8'h52, 8'd0},
        '{OP_W, A_CTRL, 8'h01, 8'd0},
        '{OP_I, 3'd0,   8'h00, 8'd0},
        '{OP_R, A_DLO,  8'h37, 8'd4},   // R4 wrap 0x52 -> 0x12
        '{OP_W, A_DHI,  8'hFF, 8'd0},
        '{OP_R, A_DHI,  8'h3F, 8'd5},   // R5 upper data bits
        '{OP_W, A_KEY,  8'h5A, 8'd0},
        '{OP_R, A_KEY,  8'h00, 8'd2},   // R2
        '{OP_W, A_DLO,  8'hC3, 8'd0},
        '{OP_W, A_CTRL, 8'h04, 8'd0},
        '{OP_W, A_KEY,  8'h55, 8'd0},
        '{OP_W, A_KEY,  8'hAA, 8'd0},
        '{OP_W, A_CTRL, 8'h06, 8'd0},   // data write to 0x12
        '{OP_I, 3'd0,   8'h00, 8'd0},
        '{OP_I, 3'd0,   8'h00, 8'd0},
        '{OP_I, 3'd0,   8'h00, 8'd0},
        '{OP_I, 3'd0,   8'h00, 8'd0},
        '{OP_I, 3'd0,   8'h00, 8'd0},
        '{OP_I, 3'd0,   8'h00, 8'd0},
        '{OP_I, 3'd0,   8'h00, 8'd0},
        '{OP_R, A_CTRL, 8'h14, 8'd7},   // R7 done set, write-go clear
        '{OP_W, A_DLO,  8'h00, 8'd0},
        '{OP_W, A_CTRL, 8'h05, 8'd0},
        '{OP_I, 3'd0,   8'h00, 8'd0},
        '{OP_R, A_DLO,  8'hC3, 8'd7}    // R7 committed value
    };

    logic              clk = 1'b0;
    logic              por_n = 1'b0, rst_n = 1'b0;
    logic              bus_we = 1'b0, bus_re = 1'b0;
    logic [2:0]        bus_addr = 3'd0;
    logic [7:0]        bus_wdata = 8'h00;
    logic [7:0]        bus_rdata;
    logic              nvm_sel, nvm_rd, nvm_wr, cpu_stall, done_irq;
    logic [12:0]       nvm_addr;
    logic [13:0]       nvm_wdata, nvm_rdata;
    logic [IRQ_W-1:0]  irq_in = '0;
    logic [IRQ_W-1:0]  irq_out;

    logic [7:0]  dmem [0:63];
    logic [13:0] pmem [0:2047];

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nvm_ctrl #(.WR_CYCLES(WR_CYC), .IRQ_W(IRQ_W)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nvm_sel(nvm_sel), .nvm_addr(nvm_addr), .nvm_wdata(nvm_wdata),
        .nvm_rd(nvm_rd), .nvm_wr(nvm_wr), .nvm_rdata(nvm_rdata),
        .cpu_stall(cpu_stall), .done_irq(done_irq),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    function automatic logic [7:0] dinit(input int i);
        return 8'(i * 3 + 1);
    endfunction

    function automatic logic [13:0] pinit(input int i);
        return 14'(i * 37 + 5);
    endfunction

    // Behavioural arrays.
    assign nvm_rdata = nvm_sel ? pmem[nvm_addr[10:0]] : {6'b0, dmem[nvm_addr[5:0]]};

    always @(posedge clk) begin
        if (nvm_wr) begin
            if (nvm_sel) pmem[nvm_addr[10:0]] <= nvm_wdata;
            else         dmem[nvm_addr[5:0]]  <= nvm_wdata[7:0];
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_re = 1'b0; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic unlock_start(input logic [7:0] ctrl);
        bus_wr(A_KEY, 8'h55);
        bus_wr(A_KEY, 8'hAA);
        bus_wr(A_CTRL, ctrl);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [13:0] w;
        int sc;
        for (int i = 0; i < 64; i++) dmem[i] = dinit(i);
        for (int i = 0; i < 2048; i++) pmem[i] = pinit(i);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 stall in reset", 16'(cpu_stall), 16'h0);
        chk("R1 irq in reset", 16'(irq_out), 16'h0);
        @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;

        // Table walk.
        for (int k = 0; k < NV; k++) begin
            case (VEC[k].op)
                OP_W: bus_wr(VEC[k].addr, VEC[k].data);
                OP_R: begin
                    bus_rd(VEC[k].addr, v);
                    chk($sformatf("R%0d row %0d", VEC[k].req, k), 16'(v), 16'(VEC[k].data));
                end
                default: begin
                    @(negedge clk);
                    bus_we = 1'b0; bus_re = 1'b0;
                    @(posedge clk); #1;
                end
            endcase
        end

        // R6: a read between the unlock steps breaks the pair.
        bus_wr(A_DLO, 8'h11);
        bus_wr(A_KEY, 8'h55);
        bus_rd(A_ADLO, v);
        bus_wr(A_KEY, 8'hAA);
        bus_wr(A_CTRL, 8'h06);
        bus_rd(A_CTRL, v);
        chk("R6 broken unlock", 16'(v), 16'h04);
        bus_wr(A_CTRL, 8'h05);
        idle(1);
        bus_rd(A_DLO, v);
        chk("R6 array unchanged", 16'(v), 16'hC3);

        // R6: correct unlock without write-enable.
        bus_wr(A_CTRL, 8'h00);
        unlock_start(8'h02);
        bus_rd(A_CTRL, v);
        chk("R6 no write-enable", 16'(v), 16'h00);

        // Program write: stall, held interrupt, locked registers.
        bus_wr(A_ADHI, 8'h00);
        bus_wr(A_ADLO, 8'h45);
        bus_wr(A_DLO, 8'h5A);
        bus_wr(A_DHI, 8'h15);
        bus_wr(A_CTRL, 8'h84);
        unlock_start(8'h86);
        chk("R10 stall on program write", 16'(cpu_stall), 16'h1);
        irq_in = 3'b010;
        bus_wr(A_CTRL, 8'h04);
        irq_in = 3'b000;
        chk("R11 irq held", 16'(irq_out), 16'h0);
        bus_rd(A_CTRL, v);
        chk("R7 R9 write-go and select kept", 16'(v), 16'h86);
        bus_wr(A_ADLO, 8'h99);
        sc = 3;
        while (cpu_stall && sc < 100) begin
            sc++;
            @(posedge clk); #1;
        end
        chk("R7 R10 write length", 16'(sc), 16'(WR_CYC));
        chk("R11 held irq released", 16'(irq_out), 16'b010);
        @(posedge clk); #1;
        chk("R11 held irq shown once", 16'(irq_out), 16'h0);
        chk("R7 done irq", 16'(done_irq), 16'h1);
        bus_rd(A_CTRL, v);
        chk("R7 control after write", 16'(v), 16'h94);
        bus_rd(A_ADLO, v);
        chk("R9 address locked", 16'(v), 16'h45);
        bus_wr(A_DLO, 8'h00);
        bus_wr(A_DHI, 8'h00);
        bus_wr(A_CTRL, 8'h85);
        idle(1);
        bus_rd(A_DLO, v);
        chk("R7 program word low", 16'(v), 16'h5A);
        bus_rd(A_DHI, v);
        chk("R7 program word high", 16'(v), 16'h15);
        irq_in = 3'b101;
        #1 chk("R11 pass through", 16'(irq_out), 16'b101);
        irq_in = 3'b000;

        // R10: data write does not stall.
        bus_wr(A_CTRL, 8'h04);
        unlock_start(8'h06);
        chk("R10 no stall on data write", 16'(cpu_stall), 16'h0);
        bus_rd(A_CTRL, v);
        chk("R7 write-go visible", 16'(v), 16'h06);
        idle(8);

        // R8: done stays until cleared.
        chk("R8 done set", 16'(done_irq), 16'h1);
        idle(5);
        chk("R8 done sticky", 16'(done_irq), 16'h1);
        bus_wr(A_CTRL, 8'h14);
        chk("R8 writing one keeps done", 16'(done_irq), 16'h1);
        bus_wr(A_CTRL, 8'h04);
        chk("R8 done cleared", 16'(done_irq), 16'h0);

        // R12: warm reset aborts a program write.
        bus_wr(A_ADHI, 8'h02);
        bus_wr(A_ADLO, 8'h30);
        bus_wr(A_DLO, 8'h77);
        bus_wr(A_DHI, 8'h01);
        bus_wr(A_CTRL, 8'h84);
        unlock_start(8'h86);
        idle(2);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        bus_rd(A_CTRL, v);
        chk("R12 error set, enable cleared", 16'(v), 16'h88);
        chk("R12 no stall after abort", 16'(cpu_stall), 16'h0);
        bus_rd(A_ADLO, v);
        chk("R12 address low kept", 16'(v), 16'h30);
        bus_rd(A_ADHI, v);
        chk("R12 address high kept", 16'(v), 16'h02);
        bus_rd(A_DLO, v);
        chk("R12 data low kept", 16'(v), 16'h77);
        bus_rd(A_DHI, v);
        chk("R12 data high kept", 16'(v), 16'h01);
        w = pinit(12'h230);
        bus_wr(A_CTRL, 8'h89);
        idle(1);
        bus_rd(A_DLO, v);
        chk("R12 array not written low", 16'(v), 16'(w[7:0]));
        bus_rd(A_DHI, v);
        chk("R12 array not written high", 16'(v), 16'(w[13:8]));
        bus_rd(A_CTRL, v);
        chk("R12 error sticky", 16'(v), 16'h88);
        bus_wr(A_CTRL, 8'h80);
        bus_rd(A_CTRL, v);
        chk("R12 error cleared by software", 16'(v), 16'h80);

        // R13: power-on reset clears all.
        bus_wr(A_CTRL, 8'h8C);
        @(negedge clk);
        por_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        por_n = 1'b1;
        bus_rd(A_CTRL, v);
        chk("R13 control cleared", 16'(v), 16'h00);
        bus_rd(A_ADHI, v);
        chk("R13 address cleared", 16'(v), 16'h00);
        bus_rd(A_DLO, v);
        chk("R13 data cleared", 16'(v), 16'h00);

        finish_run();
    end
endmodule